// File: doc/BRIEF.md
# Flash Program/Erase Protection Controller

This block sits between a CPU-side register port and the program and erase enables of a flash array. Software sets a write-unlock bit, picks program or erase mode, chooses which blocks may be erased and can select program-verify or erase-verify. From those settings the block drives a registered program enable, a registered erase enable and a per-block erase mask. A RAM-emulation bit, when set, locks the whole array.

While a program or erase enable is active, the block watches four single-cycle bus strobes: a flash read (data, instruction or vector fetch), the start of non-reset exception handling, a sleep or standby request, and a bus grant to a master other than the CPU. Any of these sets a sticky fault flag and drops both enables on the same clock edge. The register contents stay as they were. Program and erase cannot start again until reset, but the verify modes remain available.

Top module: `flash_guard`

## Requirements
- R1: While the write-unlock bit (bit 0 of register 0) is 0, prog_en and erase_en stay 0 and erase_blk_en is all zeros.
- R2: erase_blk_en[i] is 1 only while erase_en is 1 and block bit i is set. Blocks 0..7 come from register 2 and blocks 8..15 from register 3. When both registers hold zero, no block is enabled.
- R3: While the RAM-emulation bit (bit 0 of register 4) is 1, prog_en and erase_en stay 0.
- R4: A flash-read strobe in a cycle where prog_en or erase_en is 1 sets fault. At that same clock edge, both enables and the block mask drop to 0.
- R5: An exception, sleep or foreign-master strobe in a cycle where prog_en or erase_en is 1 also sets fault and aborts the operation in the same way.
- R6: Setting fault leaves registers 0, 2, 3 and 4 unchanged. They read back the values that were last written.
- R7: While fault is 1, writing the program bit (bit 1) or the erase bit (bit 2) of register 0 does not bring prog_en or erase_en back. Writes to program-verify (bit 3) and erase-verify (bit 4) still drive pverify_en and everify_en, which each follow their bit AND the write-unlock bit.
- R8: Only reset clears fault. Writes to register 1, where fault reads at bit 0, have no effect.
- R9: Strobes that arrive while prog_en and erase_en are both 0 leave fault at 0.
- R10: If the program and erase bits are both 1, neither prog_en nor erase_en asserts.
- R11: A write updates its register at the clock edge where reg_we is sampled high. reg_rdata is combinational from reg_addr. The enables reflect the register values one clock edge after the update. After reset, all registers and outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address (0 mode, 1 status, 2 blocks low, 3 blocks high, 4 emulation) |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 8 | Combinational read data |
| ev_flash_rd | input | 1 | Flash read or fetch strobe |
| ev_exception | input | 1 | Non-reset exception entry strobe |
| ev_sleep | input | 1 | Sleep or standby request strobe |
| ev_alt_master | input | 1 | Foreign bus master grant strobe |
| prog_en | output | 1 | Program enable to the array |
| erase_en | output | 1 | Erase enable to the array |
| erase_blk_en | output | 16 | Per-block erase permission |
| pverify_en | output | 1 | Program-verify enable |
| everify_en | output | 1 | Erase-verify enable |
| fault | output | 1 | Sticky runaway-error flag |

## Verification
A runaway strobe and a register write can arrive in the same cycle. For example, a strobe can coincide with a write that sets the program or erase bit, or with a write that clears the unlock bit. The bench provokes this through random cycles in which writes and strobes overlap freely. It also uses directed cases that put a flash-read strobe on the same edge as a mode write. The result is judged against a cycle model in the bench: the fault decision must come from the enables active before that edge, the enables must fall at once, and the written register must still take the new value.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned NUM_EV = 4;

  localparam logic [2:0] A_MODE   = 3'd0;
  localparam logic [2:0] A_STATUS = 3'd1;
  localparam logic [2:0] A_BLK_LO = 3'd2;
  localparam logic [2:0] A_BLK_HI = 3'd3;
  localparam logic [2:0] A_EMUL   = 3'd4;

  typedef struct packed {
    logic evfy;
    logic pvfy;
    logic ers;
    logic pgm;
    logic wen;
  } fg_mode_t;

  localparam int unsigned MODE_W = $bits(fg_mode_t);
endpackage

// File: rtl/fg_regfile.sv
module fg_regfile
  import flash_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned BLK_W  = 8,
  localparam int unsigned NBANK = 2,
  localparam int unsigned NBLK  = NBANK * BLK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              we,
  input  logic              fault,
  output fg_mode_t          mode_o,
  output logic [NBLK-1:0]   blk_o,
  output logic              emul_o,
  output logic [REG_W-1:0]  rdata
);
  fg_mode_t   mode_q;
  logic       emul_q;
  logic [BLK_W-1:0] bank_q [NBANK];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      emul_q <= 1'b0;
    end else if (we) begin
      if (addr == ADDR_W'(A_MODE)) mode_q <= fg_mode_t'(wdata[MODE_W-1:0]);
      if (addr == ADDR_W'(A_EMUL)) emul_q <= wdata[0];
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] BADDR = ADDR_W'(A_BLK_LO) + ADDR_W'(b);
    always_ff @(posedge clk) begin
      if (rst) bank_q[b] <= '0;
      else if (we && addr == BADDR) bank_q[b] <= wdata[BLK_W-1:0];
    end
    assign blk_o[b*BLK_W +: BLK_W] = bank_q[b];
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(A_MODE):   rdata[MODE_W-1:0] = mode_q;
      ADDR_W'(A_STATUS): rdata[0] = fault;
      ADDR_W'(A_BLK_LO): rdata[BLK_W-1:0] = bank_q[0];
      ADDR_W'(A_BLK_HI): rdata[BLK_W-1:0] = bank_q[1];
      ADDR_W'(A_EMUL):   rdata[0] = emul_q;
      default:           rdata = '0;
    endcase
  end

  assign mode_o = mode_q;
  assign emul_o = emul_q;

  // Registers keep their value without a write, fault or not
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(mode_q)) else $error("mode changed without write"); // R6
  AST_EMUL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(emul_q)) else $error("emul changed without write"); // R6
endmodule

// File: rtl/fg_runaway.sv
module fg_runaway
  import flash_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EV-1:0] ev,
  input  logic              active,
  output logic              fault_next,
  output logic              fault_q
);
  logic hit;

  assign hit        = active & (|ev);
  assign fault_next = fault_q | hit;

  always_ff @(posedge clk) begin
    if (rst) fault_q <= 1'b0;
    else     fault_q <= fault_next;
  end

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    fault_q |=> fault_q) else $error("fault cleared without reset"); // R8
  AST_FAULT_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    (!active && !fault_q) |=> !fault_q) else $error("fault set while idle"); // R9
endmodule

// File: rtl/fg_enable.sv
module fg_enable
  import flash_guard_pkg::*;
#(
  parameter int unsigned NBLK = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  fg_mode_t        mode,
  input  logic [NBLK-1:0] blk,
  input  logic            emul,
  input  logic            fault_next,
  output logic            prog_q,
  output logic            erase_q,
  output logic [NBLK-1:0] mask_q,
  output logic            pv_q,
  output logic            ev_q
);
  logic unlocked;
  logic prog_d, erase_d;

  assign unlocked = mode.wen & ~emul & ~fault_next;
  assign prog_d   = unlocked & mode.pgm & ~mode.ers;
  assign erase_d  = unlocked & mode.ers & ~mode.pgm;

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_q  <= 1'b0;
      erase_q <= 1'b0;
      pv_q    <= 1'b0;
      ev_q    <= 1'b0;
    end else begin
      prog_q  <= prog_d;
      erase_q <= erase_d;
      pv_q    <= mode.wen & mode.pvfy;
      ev_q    <= mode.wen & mode.evfy;
    end
  end

  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    always_ff @(posedge clk) begin
      if (rst) mask_q[i] <= 1'b0;
      else     mask_q[i] <= erase_d & blk[i];
    end
  end

  AST_ONE_MODE: assert property (@(posedge clk) disable iff (rst)
    !(prog_q && erase_q)) else $error("program and erase together"); // R10
  AST_LOCK_OFF: assert property (@(posedge clk) disable iff (rst)
    !mode.wen |=> (!prog_q && !erase_q)) else $error("enable while locked"); // R1
  AST_EMUL_LOCK: assert property (@(posedge clk) disable iff (rst)
    emul |=> (!prog_q && !erase_q)) else $error("enable under emulation"); // R3
  AST_MASK_GATED: assert property (@(posedge clk) disable iff (rst)
    (|mask_q) |-> erase_q) else $error("block mask without erase"); // R2
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned BLK_W  = 8,
  localparam int unsigned NBLK  = 2 * BLK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              reg_we,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              ev_flash_rd,
  input  logic              ev_exception,
  input  logic              ev_sleep,
  input  logic              ev_alt_master,
  output logic              prog_en,
  output logic              erase_en,
  output logic [NBLK-1:0]   erase_blk_en,
  output logic              pverify_en,
  output logic              everify_en,
  output logic              fault
);
  fg_mode_t          mode;
  logic [NBLK-1:0]   blk;
  logic              emul;
  logic              fault_next;
  logic              fault_q;
  logic [NUM_EV-1:0] ev_vec;

  assign ev_vec = {ev_alt_master, ev_sleep, ev_exception, ev_flash_rd};

  fg_regfile #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .wdata(reg_wdata), .we(reg_we),
    .fault(fault_q), .mode_o(mode), .blk_o(blk), .emul_o(emul), .rdata(reg_rdata)
  );

  fg_runaway u_runaway (
    .clk(clk), .rst(rst), .ev(ev_vec), .active(prog_en | erase_en),
    .fault_next(fault_next), .fault_q(fault_q)
  );

  fg_enable #(.NBLK(NBLK)) u_enable (
    .clk(clk), .rst(rst), .mode(mode), .blk(blk), .emul(emul),
    .fault_next(fault_next), .prog_q(prog_en), .erase_q(erase_en),
    .mask_q(erase_blk_en), .pv_q(pverify_en), .ev_q(everify_en)
  );

  assign fault = fault_q;

  AST_ABORT_RD: assert property (@(posedge clk) disable iff (rst)
    ((prog_en || erase_en) && ev_flash_rd) |=> (fault && !prog_en && !erase_en))
    else $error("flash read did not abort"); // R4
  AST_ABORT_OTHER: assert property (@(posedge clk) disable iff (rst)
    ((prog_en || erase_en) && (ev_exception || ev_sleep || ev_alt_master))
    |=> (fault && !prog_en && !erase_en)) else $error("event did not abort"); // R5
  AST_NO_REENTRY: assert property (@(posedge clk) disable iff (rst)
    fault |-> (!prog_en && !erase_en && erase_blk_en == '0))
    else $error("enable under fault"); // R7
endmodule

// File: tb/flash_guard_tb.sv
module flash_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NBLK = 16;

  logic clk = 1'b0;
  logic rst;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic reg_we;
  logic [7:0] reg_rdata;
  logic ev_flash_rd, ev_exception, ev_sleep, ev_alt_master;
  logic prog_en, erase_en, pverify_en, everify_en, fault;
  logic [NBLK-1:0] erase_blk_en;

  int checks = 0;
  int fails  = 0;

  // bench model state
  logic [4:0]  m_mode;
  logic [15:0] m_blk;
  logic        m_emul, m_fault, m_pa, m_ea, m_pv, m_ev;
  logic [15:0] m_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_guard dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .ev_flash_rd(ev_flash_rd), .ev_exception(ev_exception),
    .ev_sleep(ev_sleep), .ev_alt_master(ev_alt_master), .prog_en(prog_en),
    .erase_en(erase_en), .erase_blk_en(erase_blk_en), .pverify_en(pverify_en),
    .everify_en(everify_en), .fault(fault)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return {3'b0, m_mode};
      3'd1: return {7'b0, m_fault};
      3'd2: return m_blk[7:0];
      3'd3: return m_blk[15:8];
      3'd4: return {7'b0, m_emul};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset();
    m_mode = '0; m_blk = '0; m_emul = 0; m_fault = 0;
    m_pa = 0; m_ea = 0; m_pv = 0; m_ev = 0; m_mask = '0;
  endtask

  task automatic model_step(input logic we, input logic [2:0] a, input logic [7:0] d,
                            input logic [3:0] evs);
    logic fn, ok;
    fn = m_fault | ((m_pa | m_ea) & (|evs));
    ok = m_mode[0] & ~m_emul & ~fn;
    m_pa = ok & m_mode[1] & ~m_mode[2];
    m_ea = ok & m_mode[2] & ~m_mode[1];
    m_mask = m_ea ? m_blk : '0;
    m_pv = m_mode[0] & m_mode[3];
    m_ev = m_mode[0] & m_mode[4];
    m_fault = fn;
    if (we) begin
      if (a == 3'd0) m_mode = d[4:0];
      if (a == 3'd2) m_blk[7:0] = d;
      if (a == 3'd3) m_blk[15:8] = d;
      if (a == 3'd4) m_emul = d[0];
    end
  endtask

  task automatic compare_all(input string ctx);
    check({ctx, " R1/R3/R10 prog_en"}, prog_en, m_pa);
    check({ctx, " R1/R3/R10 erase_en"}, erase_en, m_ea);
    check({ctx, " R2 erase_blk_en"}, erase_blk_en, m_mask);
    check({ctx, " R4/R5/R8/R9 fault"}, fault, m_fault);
    check({ctx, " R7 pverify_en"}, pverify_en, m_pv);
    check({ctx, " R7 everify_en"}, everify_en, m_ev);
    check({ctx, " R6/R11 reg_rdata"}, reg_rdata, model_read(reg_addr));
  endtask

  // one clock: drive after negedge, model the edge, compare at next negedge
  task automatic cycle(input logic we, input logic [2:0] a, input logic [7:0] d,
                       input logic [3:0] evs, input string ctx);
    reg_we = we; reg_addr = a; reg_wdata = d;
    {ev_alt_master, ev_sleep, ev_exception, ev_flash_rd} = evs;
    @(posedge clk);
    model_step(we, a, d, evs);
    @(negedge clk);
    compare_all(ctx);
    reg_we = 0;
    {ev_alt_master, ev_sleep, ev_exception, ev_flash_rd} = '0;
  endtask

  task automatic idle(input string ctx);
    cycle(1'b0, reg_addr, 8'h00, 4'b0, ctx);
  endtask

  task automatic do_reset();
    rst = 1;
    reg_we = 0; reg_addr = 0; reg_wdata = 0;
    {ev_alt_master, ev_sleep, ev_exception, ev_flash_rd} = '0;
    @(posedge clk); @(posedge clk);
    model_reset();
    @(negedge clk);
    rst = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    compare_all("R11 reset state");

    // R1: locked - program bit alone does nothing
    cycle(1, 3'd0, 8'h02, 4'b0, "R1 write pgm only");
    idle("R1 locked");
    check("R1 prog_en locked", prog_en, 1'b0);

    // R11: latency, unlock+program
    cycle(1, 3'd0, 8'h03, 4'b0, "R11 write unlock+pgm");
    check("R11 prog_en one edge after register", prog_en, 1'b0);
    idle("R11 wait");
    check("R11 prog_en asserted", prog_en, 1'b1);

    // R10: both bits
    cycle(1, 3'd0, 8'h07, 4'b0, "R10 write both");
    idle("R10 wait");
    check("R10 neither asserts", {prog_en, erase_en}, 2'b00);

    // R2: erase with zero block regs, then patterns
    cycle(1, 3'd0, 8'h05, 4'b0, "R2 erase mode");
    idle("R2 wait");
    check("R2 erase_en on", erase_en, 1'b1);
    check("R2 zero registers give zero mask", erase_blk_en, 16'h0000);
    cycle(1, 3'd2, 8'hA5, 4'b0, "R2 low bank");
    cycle(1, 3'd3, 8'h3C, 4'b0, "R2 high bank");
    idle("R2 wait");
    check("R2 mask pattern", erase_blk_en, 16'h3CA5);

    // R3: emulation locks
    cycle(1, 3'd4, 8'h01, 4'b0, "R3 emul on");
    idle("R3 wait");
    check("R3 erase_en blocked", erase_en, 1'b0);
    cycle(1, 3'd4, 8'h00, 4'b0, "R3 emul off");
    idle("R3 wait off");
    check("R3 erase_en back", erase_en, 1'b1);

    // R9: events while idle do nothing
    cycle(1, 3'd0, 8'h01, 4'b0, "R9 unlock only");
    idle("R9 wait");
    cycle(0, 3'd1, 8'h00, 4'b1111, "R9 all events idle");
    check("R9 fault stays 0", fault, 1'b0);

    // R4: flash read during program aborts at once
    cycle(1, 3'd0, 8'h03, 4'b0, "R4 program");
    idle("R4 wait");
    cycle(0, 3'd1, 8'h00, 4'b0001, "R4 flash read");
    check("R4 fault set", fault, 1'b1);
    check("R4 prog_en dropped same edge", prog_en, 1'b0);

    // R6: registers retained
    cycle(0, 3'd0, 8'h00, 4'b0, "R6 read mode");
    check("R6 mode kept", reg_rdata, 8'h03);
    cycle(0, 3'd3, 8'h00, 4'b0, "R6 read high bank");
    check("R6 high bank kept", reg_rdata, 8'h3C);

    // R7: re-entry blocked, verify reachable
    cycle(1, 3'd0, 8'h05, 4'b0, "R7 rewrite erase");
    idle("R7 wait");
    check("R7 erase_en stays 0", erase_en, 1'b0);
    cycle(1, 3'd0, 8'h09, 4'b0, "R7 pverify");
    idle("R7 wait pv");
    check("R7 pverify_en under fault", pverify_en, 1'b1);
    cycle(1, 3'd0, 8'h11, 4'b0, "R7 everify");
    idle("R7 wait ev");
    check("R7 everify_en under fault", everify_en, 1'b1);

    // R8: status write ignored
    cycle(1, 3'd1, 8'h00, 4'b0, "R8 write status");
    check("R8 fault not cleared", fault, 1'b1);
    do_reset();
    check("R8 reset clears fault", fault, 1'b0);

    // R5: each other event aborts erase
    for (int k = 1; k < 4; k++) begin
      do_reset();
      cycle(1, 3'd2, 8'hFF, 4'b0, "R5 blocks");
      cycle(1, 3'd0, 8'h05, 4'b0, "R5 erase");
      idle("R5 wait");
      cycle(0, 3'd1, 8'h00, 4'(1 << k), "R5 event");
      check("R5 fault set", fault, 1'b1);
      check("R5 mask cleared", erase_blk_en, 16'h0000);
    end

    // collision: flash read on the same edge as a mode write (R4/R11)
    do_reset();
    cycle(1, 3'd0, 8'h03, 4'b0, "R4 collide setup");
    idle("R4 collide wait");
    cycle(1, 3'd0, 8'h05, 4'b0001, "R4 collide write+read");
    idle("R4 collide after");
    check("R4 collide no erase after fault", erase_en, 1'b0);

    // random phase, biased toward unlocked program/erase
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] a;
      logic [7:0] d;
      logic [3:0] e;
      logic w;
      a = 3'($urandom_range(0, 5));
      d = 8'($urandom);
      if (a == 3'd0 && ($urandom_range(0, 3) != 0)) d = {3'b0, 4'($urandom) & 4'b0011, 1'b1} | 8'($urandom_range(0, 1) << 2);
      w = ($urandom_range(0, 3) == 0);
      e = '0;
      for (int j = 0; j < 4; j++) if ($urandom_range(0, 29) == 0) e[j] = 1'b1;
      if ($urandom_range(0, 199) == 0) do_reset();
      cycle(w, a, d, e, "R11 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule